// File: doc/BRIEF.md
# PIPE Power and Idle Channel Controller

This block is the per-channel control slice that sits between a PCIe-style MAC and a transceiver channel's transmit and receive datapath. The MAC selects one of four link power states through a 2-bit power-down input. The block holds the transmit buffer in electrical idle whenever the MAC asks for idle or the channel is in any low-power state. It reports each completed power-state change with a single-cycle status pulse.

The block also runs the receiver-detect handshake. In the deepest idle-capable state, the MAC may ask for a far-end receiver probe. The block raises a request to the analog side and waits for the done indication. It then reports the result on the receive status code, in the same cycle as the completion pulse. Outside that reporting cycle, the 3-bit receive status carries the highest-priority receive error seen on the previous cycle.

During compliance-pattern transmission, the block raises a strobe that tells the 8b/10b encoder to force negative running disparity for the current character.

Top module: `pipeChanCtl`

## Requirements
- R1: While reset is asserted, the channel sits in P1 with `txIdleEn`=1, `rxStatus`=3'b000, `detectReq`=0 and `phyStatus`=0. After reset is released, `phyStatus` gives exactly one pulse, on the STATUS_DELAY-th rising edge.
- R2: The `powerDown` encoding is 2'b00 = P0, 2'b01 = P0s, 2'b10 = P1 and 2'b11 = P2. In P0 with `txIdleReq` low, `txIdleEn` is 0 from the edge that samples 2'b00 onward.
- R3: `txIdleReq` high forces `txIdleEn` high in the same cycle, in every power state.
- R4: In P0s, P1 and P2, `txIdleEn` is 1 from the edge that samples the new `powerDown` value onward.
- R5: A change of `powerDown` sampled on edge E0 produces a one-cycle `phyStatus` pulse after edge E0+STATUS_DELAY. A further change sampled before the pulse restarts the count from its own edge, and no earlier pulse appears.
- R6: A receiver detect starts only when the channel is in P1, `txIdleReq` is high and `detectLoop` rises (0 on one edge, 1 on the next). `detectReq` goes high at the edge that samples the rise. In any other state, or with `txIdleReq` low, the rise is ignored and `detectReq` stays 0.
- R7: `detectReq` stays high until an edge samples `detectDone`=1, and falls at that edge. Counting from that edge (E0), `phyStatus` pulses after E0+STATUS_DELAY. In the same cycle `rxStatus` is 3'b011 if `detectPresent` was 1 at the done edge, or 3'b000 if it was 0.
- R8: `dispForceNeg` is high, combinationally, exactly when `complianceIn` and `txCharValid` are both high, the channel is in P0 and `txIdleReq` is low.
- R9: Outside a detect-report cycle, `rxStatus` shows on the cycle after each edge the error seen at that edge: 3'b100 decode error, 3'b111 disparity error, 3'b101 elastic-buffer overflow, 3'b000 none.
- R10: When errors coincide, decode error wins over disparity error, and disparity error wins over overflow.
- R11: In the detect-report cycle the detect result replaces any error code on `rxStatus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerDown | input | 2 | Requested power state (00 P0, 01 P0s, 10 P1, 11 P2) |
| txIdleReq | input | 1 | MAC request for transmit electrical idle |
| detectLoop | input | 1 | Receiver-detect / loopback request; a rise starts a detect |
| complianceIn | input | 1 | Current character belongs to the compliance pattern |
| txCharValid | input | 1 | A transmit character is presented this cycle |
| detectDone | input | 1 | Analog side has finished the receiver probe |
| detectPresent | input | 1 | Probe result: far-end receiver found |
| rxDecodeErr | input | 1 | 8b/10b decode error on the receive path |
| rxDispErr | input | 1 | Running-disparity error on the receive path |
| rxOverflow | input | 1 | Elastic buffer overflow |
| txIdleEn | output | 1 | Holds the transmit buffer in electrical idle |
| dispForceNeg | output | 1 | Encoder strobe forcing negative disparity for this character |
| detectReq | output | 1 | Receiver probe request to the analog side |
| phyStatus | output | 1 | One-cycle completion pulse |
| rxStatus | output | 3 | Receive status / detect-result code |

## Verification
The bench builds the block with STATUS_DELAY=3. At that value the completion pulse falls close to the edges the bench drives, so one run can check each edge around it. A power change made one cycle into a running count checks the restart rule without a long wait. A detect report can be lined up against a held decode error to check the override. The compliance strobe and idle forcing are combinational, so they are checked in the same cycle as the input changes.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;

  typedef enum logic [1:0] {
    PWR_P0  = 2'b00,
    PWR_P0S = 2'b01,
    PWR_P1  = 2'b10,
    PWR_P2  = 2'b11
  } pwrState_t;

  localparam logic [2:0] RXS_OK   = 3'b000;
  localparam logic [2:0] RXS_DET  = 3'b011;
  localparam logic [2:0] RXS_DEC  = 3'b100;
  localparam logic [2:0] RXS_DISP = 3'b111;
  localparam logic [2:0] RXS_OVF  = 3'b101;

  // strobes from control to datapath
  typedef struct packed {
    logic fireStatus;    // completion pulse is due this cycle
    logic reportDetect;  // pulse belongs to a finished detect
    logic rcvPresent;    // latched detect result
    logic lowPower;      // channel in P0s, P1 or P2
  } ctlStrobe_t;

endpackage

// File: rtl/pipeCtlFsm.sv
module pipeCtlFsm
  import pipe_ctl_pkg::*;
#(
  parameter int STATUS_DELAY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] powerDown,
  input  logic       txIdleReq,
  input  logic       detectLoop,
  input  logic       detectDone,
  input  logic       detectPresent,
  output logic       detectReq,
  output ctlStrobe_t strobes
);

  localparam int CNT_W = $clog2(STATUS_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STATUS_DELAY);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  pwrState_t        pwrQ;
  logic [CNT_W-1:0] cnt;
  logic             loopQ;
  logic             detPend;
  logic             presentQ;
  logic             pdChange;
  logic             startDet;
  logic             fire;

  assign pdChange = (pwrState_t'(powerDown) != pwrQ);
  assign fire     = (cnt == CNT_ONE);
  assign startDet = (pwrQ == PWR_P1) && txIdleReq && detectLoop && !loopQ
                    && !detectReq && !detPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrQ      <= PWR_P1;
      cnt       <= CNT_LOAD;
      loopQ     <= 1'b0;
      detectReq <= 1'b0;
      detPend   <= 1'b0;
      presentQ  <= 1'b0;
    end else begin
      loopQ <= detectLoop;
      pwrQ  <= pwrState_t'(powerDown);
      if (cnt != '0) cnt <= cnt - CNT_ONE;
      if (fire) detPend <= 1'b0;
      if (startDet) detectReq <= 1'b1;
      if (detectReq && detectDone) begin
        detectReq <= 1'b0;
        detPend   <= 1'b1;
        presentQ  <= detectPresent;
        cnt       <= CNT_LOAD;
      end
      if (pdChange) cnt <= CNT_LOAD;
    end
  end

  always_comb begin
    strobes.fireStatus   = fire;
    strobes.reportDetect = fire && detPend;
    strobes.rcvPresent   = presentQ;
    strobes.lowPower     = (pwrQ != PWR_P0);
  end

  // R6: a probe request may only rise out of P1 with idle requested
  a_r6_detect_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detectReq) |-> $past(pwrQ == PWR_P1 && txIdleReq));

  // R7: the request drops at the edge that sees done
  a_r7_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    (detectReq && detectDone) |=> !detectReq);

endmodule

// File: rtl/pipeCtlDatapath.sv
module pipeCtlDatapath
  import pipe_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobes,
  input  logic       txIdleReq,
  input  logic       complianceIn,
  input  logic       txCharValid,
  input  logic       rxDecodeErr,
  input  logic       rxDispErr,
  input  logic       rxOverflow,
  output logic       txIdleEn,
  output logic       dispForceNeg,
  output logic       phyStatus,
  output logic [2:0] rxStatus
);

  logic [2:0] errCode;
  logic       pastValid;

  always_comb begin
    if (rxDecodeErr)     errCode = RXS_DEC;
    else if (rxDispErr)  errCode = RXS_DISP;
    else if (rxOverflow) errCode = RXS_OVF;
    else                 errCode = RXS_OK;
  end

  assign txIdleEn     = txIdleReq | strobes.lowPower;
  assign dispForceNeg = complianceIn & txCharValid & ~txIdleEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyStatus <= 1'b0;
      rxStatus  <= RXS_OK;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      phyStatus <= strobes.fireStatus;
      if (strobes.reportDetect)
        rxStatus <= strobes.rcvPresent ? RXS_DET : RXS_OK;
      else
        rxStatus <= errCode;
    end
  end

  // R5: completion is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    phyStatus |=> !phyStatus);

  // R10: decode error wins whenever no detect report is due
  a_r10_decode_wins: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(rxDecodeErr && !strobes.reportDetect)) |-> (rxStatus == RXS_DEC));

  // R11: a detect report always lands with the completion pulse
  a_r11_report_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobes.reportDetect)) |-> phyStatus);

endmodule

// File: rtl/pipeChanCtl.sv
module pipeChanCtl
  import pipe_ctl_pkg::*;
#(
  parameter int STATUS_DELAY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] powerDown,
  input  logic       txIdleReq,
  input  logic       detectLoop,
  input  logic       complianceIn,
  input  logic       txCharValid,
  input  logic       detectDone,
  input  logic       detectPresent,
  input  logic       rxDecodeErr,
  input  logic       rxDispErr,
  input  logic       rxOverflow,
  output logic       txIdleEn,
  output logic       dispForceNeg,
  output logic       detectReq,
  output logic       phyStatus,
  output logic [2:0] rxStatus
);

  ctlStrobe_t strobes;

  pipeCtlFsm #(.STATUS_DELAY(STATUS_DELAY)) uFsm (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .txIdleReq(txIdleReq),
    .detectLoop(detectLoop), .detectDone(detectDone),
    .detectPresent(detectPresent), .detectReq(detectReq), .strobes(strobes)
  );

  pipeCtlDatapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txIdleReq(txIdleReq),
    .complianceIn(complianceIn), .txCharValid(txCharValid),
    .rxDecodeErr(rxDecodeErr), .rxDispErr(rxDispErr), .rxOverflow(rxOverflow),
    .txIdleEn(txIdleEn), .dispForceNeg(dispForceNeg),
    .phyStatus(phyStatus), .rxStatus(rxStatus)
  );

  // R4: a sampled low-power request keeps the transmitter idle
  a_r4_low_power_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerDown) != PWR_P0) |-> txIdleEn);

  // R8: the disparity strobe only appears while running in P0
  a_r8_strobe_in_p0: assert property (@(posedge clk) disable iff (!rstN)
    dispForceNeg |-> ($past(powerDown) == PWR_P0));

endmodule

// File: tb/sim_pipeChanCtl.sv
`timescale 1ns/1ps
module sim_pipeChanCtl;

  localparam int D = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] powerDown = 2'b10;
  logic txIdleReq = 1'b0, detectLoop = 1'b0, complianceIn = 1'b0, txCharValid = 1'b0;
  logic detectDone = 1'b0, detectPresent = 1'b0;
  logic rxDecodeErr = 1'b0, rxDispErr = 1'b0, rxOverflow = 1'b0;
  logic txIdleEn, dispForceNeg, detectReq, phyStatus;
  logic [2:0] rxStatus;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pipeChanCtl #(.STATUS_DELAY(D)) u0 (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .txIdleReq(txIdleReq),
    .detectLoop(detectLoop), .complianceIn(complianceIn), .txCharValid(txCharValid),
    .detectDone(detectDone), .detectPresent(detectPresent),
    .rxDecodeErr(rxDecodeErr), .rxDispErr(rxDispErr), .rxOverflow(rxOverflow),
    .txIdleEn(txIdleEn), .dispForceNeg(dispForceNeg), .detectReq(detectReq),
    .phyStatus(phyStatus), .rxStatus(rxStatus)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // after a sampled change: D-1 quiet cycles, pulse, quiet
  task automatic expectPulse(input string tag);
    for (int i = 0; i < D - 1; i++) begin
      step();
      chk({tag, " early"}, phyStatus, 0);
    end
    step();
    chk({tag, " pulse"}, phyStatus, 1);
    step();
    chk({tag, " after"}, phyStatus, 0);
  endtask

  task automatic setPower(input logic [1:0] pd, input string tag);
    powerDown = pd;
    step();
    chk({tag, " capture"}, phyStatus, 0);
    expectPulse(tag);
  endtask

  task automatic tReset();
    step(); step();
    chk("R1 idle in reset", txIdleEn, 1);
    chk("R1 rxStatus in reset", rxStatus, 0);
    chk("R1 detectReq in reset", detectReq, 0);
    chk("R1 phyStatus in reset", phyStatus, 0);
    rstN = 1'b1;
    expectPulse("R1 post-reset");
  endtask

  task automatic tPowerStates();
    setPower(2'b00, "R5 to P0");
    chk("R2 P0 not idle", txIdleEn, 0);
    setPower(2'b01, "R5 to P0s");
    chk("R4 P0s idle", txIdleEn, 1);
    setPower(2'b11, "R5 to P2");
    chk("R4 P2 idle", txIdleEn, 1);
    setPower(2'b00, "R5 back to P0");
    chk("R2 P0 again", txIdleEn, 0);
  endtask

  task automatic tIdleForce();
    txIdleReq = 1'b1;
    #1;
    chk("R3 idle forced in P0", txIdleEn, 1);
    txIdleReq = 1'b0;
    #1;
    chk("R3 idle released", txIdleEn, 0);
  endtask

  task automatic tRestart();
    powerDown = 2'b01;
    step();
    step();
    chk("R5 restart no pulse yet", phyStatus, 0);
    powerDown = 2'b10;
    step();
    chk("R5 restart capture", phyStatus, 0);
    expectPulse("R5 restarted");
  endtask

  task automatic tCompliance();
    setPower(2'b00, "R8 setup P0");
    complianceIn = 1'b1; txCharValid = 1'b1;
    #1;
    chk("R8 strobe on compliance char", dispForceNeg, 1);
    txCharValid = 1'b0;
    #1;
    chk("R8 no strobe without char", dispForceNeg, 0);
    txCharValid = 1'b1; complianceIn = 1'b0;
    #1;
    chk("R8 no strobe without compliance", dispForceNeg, 0);
    complianceIn = 1'b1; txIdleReq = 1'b1;
    #1;
    chk("R8 no strobe while idle", dispForceNeg, 0);
    txIdleReq = 1'b0;
    complianceIn = 1'b0; txCharValid = 1'b0;
  endtask

  task automatic tDetectGate();
    // in P0 with idle requested: rise ignored
    txIdleReq = 1'b1;
    detectLoop = 1'b1;
    step(); step();
    chk("R6 ignored in P0", detectReq, 0);
    detectLoop = 1'b0;
    txIdleReq = 1'b0;
    setPower(2'b10, "R6 setup P1");
    detectLoop = 1'b1;
    step(); step();
    chk("R6 ignored without idle", detectReq, 0);
    detectLoop = 1'b0;
    step();
  endtask

  task automatic tDetect(input logic present, input logic holdErr);
    txIdleReq = 1'b1;
    detectLoop = 1'b1;
    step();
    chk("R6 detectReq raised", detectReq, 1);
    step();
    chk("R7 detectReq held", detectReq, 1);
    detectDone = 1'b1; detectPresent = present;
    step();
    chk("R7 detectReq dropped", detectReq, 0);
    detectDone = 1'b0; detectPresent = 1'b0; detectLoop = 1'b0;
    rxDecodeErr = holdErr;
    for (int i = 0; i < D - 1; i++) begin
      step();
      chk("R7 no early pulse", phyStatus, 0);
    end
    step();
    chk("R7 detect pulse", phyStatus, 1);
    if (holdErr) chk("R11 result over error", rxStatus, present ? 3 : 0);
    else         chk("R7 detect result", rxStatus, present ? 3 : 0);
    step();
    chk("R7 pulse ended", phyStatus, 0);
    chk("R11 error code resumes", rxStatus, holdErr ? 4 : 0);
    rxDecodeErr = 1'b0;
    txIdleReq = 1'b0;
    step();
  endtask

  task automatic tErrors();
    rxOverflow = 1'b1;
    step();
    chk("R9 overflow", rxStatus, 5);
    rxOverflow = 1'b0; rxDispErr = 1'b1;
    step();
    chk("R9 disparity", rxStatus, 7);
    rxDispErr = 1'b0; rxDecodeErr = 1'b1;
    step();
    chk("R9 decode", rxStatus, 4);
    rxDecodeErr = 1'b0;
    step();
    chk("R9 clear", rxStatus, 0);
    rxDispErr = 1'b1; rxOverflow = 1'b1;
    step();
    chk("R10 disparity over overflow", rxStatus, 7);
    rxDecodeErr = 1'b1;
    step();
    chk("R10 decode over all", rxStatus, 4);
    rxDecodeErr = 1'b0; rxDispErr = 1'b0; rxOverflow = 1'b0;
    step();
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tReset();
    tPowerStates();
    tIdleForce();
    tRestart();
    tCompliance();
    tDetectGate();
    tDetect(1'b1, 1'b0);
    tDetect(1'b0, 1'b0);
    tDetect(1'b1, 1'b1);
    tErrors();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule